// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block drives the element loop of one vectorised operation. A start pulse captures a vector length, a starting source step and a starting destination step, two predicate masks and two scalar/vector operand flags. The block then hands out one (source element, destination element) pair per clock to a downstream datapath, using a valid/ready handshake. It raises a one-cycle completion pulse when the loop ends.

The source and destination masks act independently. The source step skips disabled source elements and the destination step skips disabled destination elements, so one pass can compress, expand, or do both at once. Each mask is built inside the block from one of several predicate modes: all elements, a register value, its inverse, a one-hot shift, or the equal bits of condition fields. The loop can resume from preset step values. It ends early when the destination is scalar. When it finishes, both steps return to zero.

Top module: `vseq_sequencer`

## Requirements
- R1: With a latched vector length of zero, `done_o` pulses in the first cycle after the start edge and `valid_o` is never raised.
- R2: Each issued pair holds the lowest enabled source position at or above the source step and the lowest enabled destination position at or above the destination step. After a handshake each step moves to one past the position just used.
- R3: The loop ends as soon as either step finds no enabled position below the vector length. Positions that are not reached are never issued.
- R4: When the destination is scalar, the loop ends after the first accepted pair and `dst_idx_o` reads 0. When the source is scalar, `src_idx_o` reads 0 for every pair, while the source mask still gates the stepping.
- R5: Nonzero starting steps are honoured. Mask bits below the starting step are ignored.
- R6: In the cycle after `done_o`, `busy_o` is 0 and both step outputs read 0.
- R7: Mode encoding for each mask: 0 means all enabled. 1 means bit i of the register. 2 means the inverse of bit i. 3 means the one-hot value 1 shifted left by the register value, which gives an empty mask when the shift is MASK_W or more.
- R8: When `shared_pred_i` is 1, the destination uses the source mask. An all-zero shared mask issues nothing, and its inverse enables every element.
- R9: Modes 4 (equal) and 5 (not equal) give element i the eq bit of condition field 4+i. Field f occupies `cr_i[4f+3:4f]`, and its eq bit is `cr_i[4f+1]`. Mode 5 inverts that bit. Fields past the end of `cr_i` read as eq=0.
- R10: While `valid_o` is high and `ready_i` is low, `valid_o`, `src_idx_o` and `dst_idx_o` stay unchanged. Exactly one pair is consumed per cycle with both high.
- R11: A start pulse while busy is ignored, and the running loop continues unchanged.
- R12: After reset, `valid_o`, `done_o` and `busy_o` are 0 and both step outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Captures the operation when idle |
| vl_i | input | STEP_W | Vector length |
| srcstep_i | input | STEP_W | Starting source step |
| dststep_i | input | STEP_W | Starting destination step |
| src_mode_i | input | 3 | Source predicate mode |
| dst_mode_i | input | 3 | Destination predicate mode |
| shared_pred_i | input | 1 | Destination reuses the source mask |
| src_reg_i | input | REG_W | Source predicate register value |
| dst_reg_i | input | REG_W | Destination predicate register value |
| cr_i | input | 4*CR_FIELDS | Condition fields |
| src_scalar_i | input | 1 | Source operand is scalar |
| dst_scalar_i | input | 1 | Destination operand is scalar |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | A pair is offered |
| src_idx_o | output | STEP_W | Source element offset |
| dst_idx_o | output | STEP_W | Destination element offset |
| done_o | output | 1 | Loop terminates this cycle |
| busy_o | output | 1 | A loop is active |
| srcstep_o | output | STEP_W | Current source step |
| dststep_o | output | STEP_W | Current destination step |

## Verification
The hardest situation to reach from the ports is a start pulse that lands in the middle of a stalled loop. In that case the first loop's offered pair must survive both the back-pressure and the rejected restart. The bench holds `ready_i` low on alternate cycles during an eight-element run and pulses `start_i` with a zero length in its second cycle. It then expects all eight original pairs, with indices held through every stall. Resuming from preset steps is reached by loading nonzero start steps together with masks whose low bits would otherwise be picked.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic [2:0] {
      PM_ALL    = 3'd0,
      PM_REG    = 3'd1,
      PM_INV    = 3'd2,
      PM_ONEHOT = 3'd3,
      PM_CR_EQ  = 3'd4,
      PM_CR_NE  = 3'd5
   } pmode_e;

   localparam int CR_BASE = 4;  // element i reads condition field CR_BASE+i
   localparam int CR_EQ_BIT = 1;
endpackage

// File: rtl/vseq_mask_gen.sv
module vseq_mask_gen #(
   parameter int MASK_W    = 64,
   parameter int REG_W     = 64,
   parameter int CR_FIELDS = 8
) (
   input  logic [2:0]             mode_i,
   input  logic [REG_W-1:0]       reg_i,
   input  logic [4*CR_FIELDS-1:0] cr_i,
   output logic [MASK_W-1:0]      mask_o
);
   import vseq_pkg::*;

   localparam int SH_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   logic [MASK_W-1:0] cr_eq;

   for (genvar gi = 0; gi < MASK_W; gi++) begin : g_cr
      if (CR_BASE + gi < CR_FIELDS) begin : g_have
         assign cr_eq[gi] = cr_i[4*(CR_BASE+gi) + CR_EQ_BIT];
      end else begin : g_none
         assign cr_eq[gi] = 1'b0;
      end
   end

   logic [MASK_W-1:0] onehot;
   always_comb begin
      onehot = '0;
      if (reg_i < REG_W'(MASK_W)) onehot = MASK_W'(1) << reg_i[SH_W-1:0];
   end

   always_comb begin
      unique case (pmode_e'(mode_i))
         PM_ALL:    mask_o = '1;
         PM_REG:    mask_o = reg_i[MASK_W-1:0];
         PM_INV:    mask_o = ~reg_i[MASK_W-1:0];
         PM_ONEHOT: mask_o = onehot;
         PM_CR_EQ:  mask_o = cr_eq;
         PM_CR_NE:  mask_o = ~cr_eq;
         default:   mask_o = '0;
      endcase
   end
endmodule

// File: rtl/vseq_step_find.sv
module vseq_step_find #(
   parameter int MASK_W = 64,
   parameter int STEP_W = 7
) (
   input  logic [MASK_W-1:0] mask_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic [STEP_W-1:0] vl_i,
   output logic              found_o,
   output logic [STEP_W-1:0] pos_o
);
   // lowest enabled position in [step_i, vl_i)
   always_comb begin
      found_o = 1'b0;
      pos_o   = '0;
      for (int i = MASK_W - 1; i >= 0; i--) begin
         if (mask_i[i] && (i >= int'(step_i)) && (i < int'(vl_i))) begin
            found_o = 1'b1;
            pos_o   = STEP_W'(i);
         end
      end
   end
endmodule

// File: rtl/vseq_sequencer.sv
module vseq_sequencer #(
   parameter int STEP_W    = 7,
   parameter int MASK_W    = 64,
   parameter int REG_W     = 64,
   parameter int CR_FIELDS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [STEP_W-1:0]      vl_i,
   input  logic [STEP_W-1:0]      srcstep_i,
   input  logic [STEP_W-1:0]      dststep_i,
   input  logic [2:0]             src_mode_i,
   input  logic [2:0]             dst_mode_i,
   input  logic                   shared_pred_i,
   input  logic [REG_W-1:0]       src_reg_i,
   input  logic [REG_W-1:0]       dst_reg_i,
   input  logic [4*CR_FIELDS-1:0] cr_i,
   input  logic                   src_scalar_i,
   input  logic                   dst_scalar_i,
   input  logic                   ready_i,
   output logic                   valid_o,
   output logic [STEP_W-1:0]      src_idx_o,
   output logic [STEP_W-1:0]      dst_idx_o,
   output logic                   done_o,
   output logic                   busy_o,
   output logic [STEP_W-1:0]      srcstep_o,
   output logic [STEP_W-1:0]      dststep_o
);
   if (MASK_W > REG_W || MASK_W > (1 << STEP_W) || MASK_W < 2) begin : g_bad_params
      $error("vseq_sequencer: MASK_W must lie in [2, min(REG_W, 2**STEP_W)]");
   end

   logic [MASK_W-1:0] src_mask_c, dst_mask_c;
   logic [MASK_W-1:0] smask_q, dmask_q;
   logic [STEP_W-1:0] vl_q, sstep_q, dstep_q;
   logic              busy_q, sscal_q, dscal_q;

   vseq_mask_gen #(.MASK_W(MASK_W), .REG_W(REG_W), .CR_FIELDS(CR_FIELDS)) u_src_mask (
      .mode_i(src_mode_i), .reg_i(src_reg_i), .cr_i(cr_i), .mask_o(src_mask_c));

   vseq_mask_gen #(.MASK_W(MASK_W), .REG_W(REG_W), .CR_FIELDS(CR_FIELDS)) u_dst_mask (
      .mode_i(dst_mode_i), .reg_i(dst_reg_i), .cr_i(cr_i), .mask_o(dst_mask_c));

   logic              s_found, d_found;
   logic [STEP_W-1:0] s_pos, d_pos;

   vseq_step_find #(.MASK_W(MASK_W), .STEP_W(STEP_W)) u_src_find (
      .mask_i(smask_q), .step_i(sstep_q), .vl_i(vl_q), .found_o(s_found), .pos_o(s_pos));

   vseq_step_find #(.MASK_W(MASK_W), .STEP_W(STEP_W)) u_dst_find (
      .mask_i(dmask_q), .step_i(dstep_q), .vl_i(vl_q), .found_o(d_found), .pos_o(d_pos));

   logic fin, fire;
   assign valid_o   = busy_q && s_found && d_found;
   assign fin       = busy_q && !(s_found && d_found);
   assign fire      = valid_o && ready_i;
   assign done_o    = fin;
   assign busy_o    = busy_q;
   assign src_idx_o = sscal_q ? '0 : s_pos;
   assign dst_idx_o = dscal_q ? '0 : d_pos;
   assign srcstep_o = sstep_q;
   assign dststep_o = dstep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         vl_q    <= '0;
         sstep_q <= '0;
         dstep_q <= '0;
         smask_q <= '0;
         dmask_q <= '0;
         sscal_q <= 1'b0;
         dscal_q <= 1'b0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            vl_q    <= vl_i;
            sstep_q <= srcstep_i;
            dstep_q <= dststep_i;
            smask_q <= src_mask_c;
            dmask_q <= shared_pred_i ? src_mask_c : dst_mask_c;
            sscal_q <= src_scalar_i;
            dscal_q <= dst_scalar_i;
         end
      end else if (fin) begin
         busy_q  <= 1'b0;
         sstep_q <= '0;
         dstep_q <= '0;
      end else if (fire) begin
         sstep_q <= s_pos + STEP_W'(1);
         dstep_q <= dscal_q ? vl_q : d_pos + STEP_W'(1);
      end
   end
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
   parameter int STEP_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ready_i,
   input logic              valid_o,
   input logic [STEP_W-1:0] src_idx_o,
   input logic [STEP_W-1:0] dst_idx_o,
   input logic              done_o,
   input logic              busy_o,
   input logic [STEP_W-1:0] srcstep_o,
   input logic [STEP_W-1:0] dststep_o,
   input logic [STEP_W-1:0] vl_q,
   input logic              sscal_q,
   input logic              dscal_q
);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(src_idx_o) && $stable(dst_idx_o));

   p_done_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o && busy_o);

   p_steps_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o && srcstep_o == '0 && dststep_o == '0);

   p_dst_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !dscal_q |-> dst_idx_o < vl_q);

   p_src_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !sscal_q |-> src_idx_o < vl_q);

   p_scalar_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && sscal_q |-> src_idx_o == '0);

   p_scalar_dst_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i && dscal_q |=> done_o);

   p_busy_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o && start_i |=> busy_o && $stable(vl_q));

   p_valid_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> busy_o);
endmodule

bind vseq_sequencer vseq_checker #(.STEP_W(STEP_W)) u_vseq_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
   .valid_o(valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
   .done_o(done_o), .busy_o(busy_o), .srcstep_o(srcstep_o), .dststep_o(dststep_o),
   .vl_q(vl_q), .sscal_q(sscal_q), .dscal_q(dscal_q));

// File: tb/vseq_sequencer_tb.sv
module vseq_sequencer_tb_top;
   localparam int STEP_W = 7;
   localparam int MASK_W = 64;
   localparam int REG_W  = 64;
   localparam int CRF    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [STEP_W-1:0] vl_i = '0, srcstep_i = '0, dststep_i = '0;
   logic [2:0] src_mode_i = '0, dst_mode_i = '0;
   logic shared_pred_i = 1'b0;
   logic [REG_W-1:0] src_reg_i = '0, dst_reg_i = '0;
   logic [4*CRF-1:0] cr_i = '0;
   logic src_scalar_i = 1'b0, dst_scalar_i = 1'b0, ready_i = 1'b0;
   logic valid_o, done_o, busy_o;
   logic [STEP_W-1:0] src_idx_o, dst_idx_o, srcstep_o, dststep_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   vseq_sequencer #(.STEP_W(STEP_W), .MASK_W(MASK_W), .REG_W(REG_W), .CR_FIELDS(CRF)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
      .srcstep_i(srcstep_i), .dststep_i(dststep_i),
      .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i), .shared_pred_i(shared_pred_i),
      .src_reg_i(src_reg_i), .dst_reg_i(dst_reg_i), .cr_i(cr_i),
      .src_scalar_i(src_scalar_i), .dst_scalar_i(dst_scalar_i), .ready_i(ready_i),
      .valid_o(valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
      .done_o(done_o), .busy_o(busy_o), .srcstep_o(srcstep_o), .dststep_o(dststep_o));

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Mask as the requirements define it (R7, R9)
   function automatic logic [MASK_W-1:0] ref_mask(input int mode, input logic [REG_W-1:0] r,
                                                  input logic [4*CRF-1:0] cr);
      logic [MASK_W-1:0] m;
      m = '0;
      for (int i = 0; i < MASK_W; i++) begin
         logic e;
         e = (4 + i < CRF) ? cr[4*(4+i)+1] : 1'b0;
         case (mode)
            0: m[i] = 1'b1;
            1: m[i] = r[i];
            2: m[i] = ~r[i];
            3: m[i] = (r == REG_W'(i));
            4: m[i] = e;
            5: m[i] = ~e;
            default: m[i] = 1'b0;
         endcase
      end
      return m;
   endfunction

   // One scenario: start, consume all pairs, compare with the element-loop model.
   task automatic run_case(input string req, input int vl, input int ss, input int ds,
                           input int sm, input int dm, input bit shared,
                           input logic [REG_W-1:0] sr, input logic [REG_W-1:0] dr,
                           input logic [4*CRF-1:0] cr, input bit sscal, input bit dscal,
                           input bit stall, input bit poke, output int first_done);
      logic [MASK_W-1:0] smk, dmk;
      int es[MASK_W];
      int ed[MASK_W];
      int n, s, d, k, cyc;
      bit pv, pr, seen_done;
      logic [STEP_W-1:0] ps, pd;
      smk = ref_mask(sm, sr, cr);
      dmk = shared ? smk : ref_mask(dm, dr, cr);
      n = 0; s = ss; d = ds;
      forever begin
         while (s < vl && !smk[s]) s++;
         while (d < vl && !dmk[d]) d++;
         if (s >= vl || d >= vl) break;
         es[n] = sscal ? 0 : s;
         ed[n] = dscal ? 0 : d;
         n++;
         if (dscal) break;
         s++; d++;
      end
      @(negedge clk);
      vl_i = STEP_W'(vl); srcstep_i = STEP_W'(ss); dststep_i = STEP_W'(ds);
      src_mode_i = 3'(sm); dst_mode_i = 3'(dm); shared_pred_i = shared;
      src_reg_i = sr; dst_reg_i = dr; cr_i = cr;
      src_scalar_i = sscal; dst_scalar_i = dscal;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      k = 0; pv = 0; pr = 0; ps = '0; pd = '0; seen_done = 0; first_done = -1;
      for (cyc = 0; cyc < 300; cyc++) begin
         ready_i = stall ? cyc[0] : 1'b1;
         if (poke && cyc == 1) begin
            start_i = 1'b1; vl_i = '0; srcstep_i = 7'd3;
         end else begin
            start_i = 1'b0;
         end
         #0.1;
         if (pv && !pr) begin  // R10 hold check
            chk("R10", "valid held during stall", valid_o, 1);
            chk("R10", "src idx held", src_idx_o, ps);
            chk("R10", "dst idx held", dst_idx_o, pd);
         end
         if (done_o) begin
            seen_done = 1; first_done = cyc;
            chk(req, "no valid with done", valid_o, 0);
            break;
         end
         if (valid_o && ready_i) begin
            if (k < n) begin
               chk(req, "src idx", src_idx_o, es[k]);
               chk(req, "dst idx", dst_idx_o, ed[k]);
            end else begin
               chk(req, "extra pair issued", k, n);
            end
            k++;
         end
         pv = valid_o; pr = ready_i; ps = src_idx_o; pd = dst_idx_o;
         @(posedge clk);
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(req, "done seen", seen_done, 1);
      chk(req, "pair count", k, n);
      @(posedge clk);
      @(negedge clk);
      chk("R6", "busy after done", busy_o, 0);
      chk("R6", "srcstep after done", srcstep_o, 0);
      chk("R6", "dststep after done", dststep_o, 0);
      ready_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12", "valid at reset", valid_o, 0);
      chk("R12", "done at reset", done_o, 0);
      chk("R12", "busy at reset", busy_o, 0);
      chk("R12", "srcstep at reset", srcstep_o, 0);
      chk("R12", "dststep at reset", dststep_o, 0);
   endtask

   task automatic t_vl_zero();
      int fd;
      run_case("R1", 0, 0, 0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 0, fd);
      chk("R1", "done in first cycle", fd, 0);
   endtask

   task automatic t_basic();
      int fd;
      run_case("R2", 3, 0, 0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 0, fd);
      run_case("R2", 3, 0, 0, 1, 2, 0, 64'b101, 64'b101, '0, 0, 0, 0, 0, fd);  // twin mask
      run_case("R3", 3, 0, 0, 1, 0, 0, 64'b101, '0, '0, 0, 0, 0, 0, fd);       // compress
      run_case("R3", 3, 0, 0, 0, 1, 0, '0, 64'b101, '0, 0, 0, 0, 0, fd);       // expand
   endtask

   task automatic t_resume();
      int fd;
      run_case("R5", 4, 1, 2, 1, 2, 0, 64'b0101, 64'b0101, '0, 0, 0, 0, 0, fd);
      run_case("R5", 6, 3, 1, 0, 0, 0, '0, '0, '0, 0, 0, 0, 0, fd);
   endtask

   task automatic t_modes();
      int fd;
      run_case("R7", 3, 0, 0, 1, 3, 0, 64'b100, 64'd1, '0, 0, 0, 0, 0, fd);
      run_case("R7", 3, 0, 0, 3, 1, 0, 64'd2, 64'b010, '0, 0, 0, 0, 0, fd);
      run_case("R7", 4, 0, 0, 3, 0, 0, 64'd70, '0, '0, 0, 0, 0, 0, fd);  // shift too big
   endtask

   task automatic t_scalar();
      int fd;
      run_case("R4", 2, 0, 0, 0, 0, 0, '0, '0, '0, 0, 1, 0, 0, fd);
      run_case("R4", 3, 0, 0, 0, 0, 0, '0, '0, '0, 1, 0, 0, 0, fd);
      run_case("R4", 3, 0, 0, 1, 0, 0, 64'b110, '0, '0, 0, 1, 0, 0, fd);
   endtask

   task automatic t_shared();
      int fd;
      run_case("R8", 3, 0, 0, 1, 0, 1, '0, '1, '0, 0, 0, 0, 0, fd);
      run_case("R8", 3, 0, 0, 2, 1, 1, '0, '0, '0, 0, 0, 0, 0, fd);
      run_case("R8", 3, 0, 0, 1, 0, 1, 64'b101, '0, '0, 0, 0, 0, 0, fd);
   endtask

   task automatic t_cr();
      int fd;
      run_case("R9", 2, 0, 0, 5, 0, 1, '0, '0, 32'h0002_0000, 0, 0, 0, 0, fd);
      run_case("R9", 6, 0, 0, 4, 0, 0, '0, '0, 32'h2020_0000, 0, 0, 0, 0, fd);
   endtask

   task automatic t_stall();
      int fd;
      run_case("R10", 5, 0, 0, 1, 0, 0, 64'b11011, '0, '0, 0, 0, 1, 0, fd);
   endtask

   task automatic t_restart();
      int fd;
      run_case("R11", 8, 0, 0, 0, 0, 0, '0, '0, '0, 0, 0, 1, 1, fd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vl_zero();
      t_basic();
      t_resume();
      t_modes();
      t_scalar();
      t_shared();
      t_cr();
      t_stall();
      t_restart();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule